// File: doc/BRIEF.md
# Masked vector lane extract unit

This unit takes one 128-bit or 256-bit chunk out of a 256-bit or 512-bit source vector and turns it into a new destination value. An immediate chooses which chunk is taken. Each 32-bit or 64-bit element of the result is then either written from the chunk or left unselected, according to a per-element write mask. An unselected element is either kept from the old destination (merging) or cleared (zeroing).

For a register destination, every bit above the chunk is cleared, up to the 512-bit maximum vector length. For a memory destination only merging applies, and the unit produces one byte-enable bit per destination byte so that a store writes only the selected elements. The unit also checks the encoding fields it is given and reports an undefined-opcode fault for an illegal encoding. A fault suppresses the write.

All results are registered and appear one cycle after the input strobe, together with an output valid pulse.

Top module: `vec_chunk_extract`

## Requirements
- R1: With a 256-bit source (`src_wide`=0) and a 128-bit chunk (`chunk_wide`=0), `imm[0]`=0 takes `src[127:0]` and `imm[0]`=1 takes `src[255:128]`. The chunk lands in `dst[127:0]`.
- R2: With a 512-bit source (`src_wide`=1) and a 128-bit chunk, `imm[1:0]` value k takes `src[128*k+127:128*k]`, for k from 0 to 3.
- R3: With a 256-bit chunk (`chunk_wide`=1) from a 512-bit source, `imm[0]`=0 takes `src[255:0]` and `imm[0]`=1 takes `src[511:256]`. The chunk lands in `dst[255:0]`.
- R4: Immediate bits above the index field have no effect on the result: bits 7:2 for a 128-bit chunk from a 512-bit source, and bits 7:1 otherwise.
- R5: When `mask_en`=1, result element e is written only when `mask[e]`=1. With 32-bit elements (`elem64`=0), element e is bits 32e+31:32e. With 64-bit elements (`elem64`=1), element e is bits 64e+63:64e. When `mask_en`=0, every element of the chunk is written.
- R6: With a register destination (`to_mem`=0), an unselected element takes the matching bits of `old_dst` when `zeroing`=0, and becomes zero when `zeroing`=1.
- R7: With a register destination and no fault, every `dst` bit above the chunk, up to bit 511, is zero.
- R8: With a memory destination (`to_mem`=1), `byte_en` bit b is 1 exactly when byte b belongs to a written element. Unselected and out-of-chunk bytes of `dst` keep `old_dst`, and `zeroing` has no effect. With a register destination, `byte_en` is all zero.
- R9: When `vvvv` is not 4'b1111, `fault` is 1 in the result cycle, `byte_en` is zero and `dst` keeps its previous value.
- R10: In the legacy form (`legacy`=1), `len_bit`=0 raises `fault`. With `len_bit`=1, the unit uses a 256-bit source and a 128-bit chunk chosen by `imm[0]`. All 128 bits are written regardless of `mask`, `mask_en` and `zeroing`, and the upper bits are cleared for a register destination.
- R11: `out_valid` is 1 exactly one cycle after `in_valid` is 1. `dst` holds its value in cycles with no operation. After reset `dst`, `byte_en`, `fault` and `out_valid` are zero.
- R12: A non-legacy request for a 256-bit chunk from a 256-bit source (`chunk_wide`=1, `src_wide`=0) raises `fault` with the same suppression as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for one operation |
| src | input | 512 | Source vector |
| old_dst | input | 512 | Previous destination contents |
| imm | input | 8 | Immediate; low bits pick the chunk |
| src_wide | input | 1 | 1: 512-bit source, 0: 256-bit source |
| chunk_wide | input | 1 | 1: 256-bit chunk, 0: 128-bit chunk |
| elem64 | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| mask | input | 8 | Per-element write mask |
| mask_en | input | 1 | 1: apply mask, 0: write all elements |
| zeroing | input | 1 | 1: zero unselected elements, 0: merge |
| to_mem | input | 1 | 1: memory destination, 0: register destination |
| legacy | input | 1 | Unmasked legacy-encoded form |
| len_bit | input | 1 | Length bit of the legacy form |
| vvvv | input | 4 | Reserved register field, must be 4'b1111 |
| out_valid | output | 1 | Result valid, one cycle after issue |
| dst | output | 512 | New destination value |
| byte_en | output | 64 | Store byte enables for a memory destination |
| fault | output | 1 | Undefined-opcode fault |

## Verification
The assertions assume that `in_valid` is low whenever reset is active. They also assume that the reserved field, the length bit and the chunk/source combination are the only sources of a fault. Under those assumptions, a register-destination result with no fault always has a cleared upper half, and a fault never changes `dst`.

The stimulus respects these assumptions. It holds `in_valid` low through reset and drives every input only on the falling clock edge. Its illegal encodings come only from a bad `vvvv`, a legacy form with `len_bit`=0, or a wide chunk taken from a narrow source.

// File: rtl/vec_chunk_extract.sv
module vec_chunk_extract #(
  parameter int MAXVL  = 512,
  parameter int LANE_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [MAXVL-1:0]              src,
  input  logic [MAXVL-1:0]              old_dst,
  input  logic [7:0]                    imm,
  input  logic                          src_wide,
  input  logic                          chunk_wide,
  input  logic                          elem64,
  input  logic [MAXVL/(2*LANE_W)-1:0]   mask,
  input  logic                          mask_en,
  input  logic                          zeroing,
  input  logic                          to_mem,
  input  logic                          legacy,
  input  logic                          len_bit,
  input  logic [3:0]                    vvvv,
  output logic                          out_valid,
  output logic [MAXVL-1:0]              dst,
  output logic [MAXVL/8-1:0]            byte_en,
  output logic                          fault
);
  localparam int HALF   = MAXVL / 2;
  localparam int QTR    = MAXVL / 4;
  localparam int NLANE  = HALF / LANE_W;
  localparam int LBYTES = LANE_W / 8;
  localparam int NBYTE  = MAXVL / 8;

  logic [1:0]       qidx;
  logic [QTR-1:0]   pick_qtr;
  logic [HALF-1:0]  pick_half, chunk;
  logic [MAXVL-1:0] nxt;
  logic [NBYTE-1:0] be_nxt;
  logic             wide, bad;
  logic             unused_imm;

  assign unused_imm = ^imm[7:2];
  assign qidx      = (src_wide && !legacy) ? imm[1:0] : {1'b0, imm[0]};
  assign pick_qtr  = src[int'(qidx)*QTR +: QTR];
  assign pick_half = imm[0] ? src[MAXVL-1:HALF] : src[HALF-1:0];
  assign wide      = chunk_wide && !legacy;
  assign chunk     = wide ? pick_half : {{(HALF-QTR){1'b0}}, pick_qtr};
  assign bad       = (vvvv != 4'hF) || (legacy && !len_bit) ||
                     (!legacy && chunk_wide && !src_wide);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic in_chunk, mbit, take;
    assign in_chunk = wide || (g < NLANE/2);
    assign mbit     = elem64 ? mask[g/2] : mask[g];
    assign take     = in_chunk && (legacy || !mask_en || mbit);
    assign nxt[g*LANE_W +: LANE_W] =
        take                 ? chunk[g*LANE_W +: LANE_W] :
        (to_mem || (in_chunk && !zeroing)) ? old_dst[g*LANE_W +: LANE_W] :
                               '0;
    assign be_nxt[g*LBYTES +: LBYTES] = {LBYTES{take && to_mem}};
  end

  assign nxt[MAXVL-1:HALF]      = to_mem ? old_dst[MAXVL-1:HALF] : '0;
  assign be_nxt[NBYTE-1:HALF/8] = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      byte_en   <= '0;
      fault     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      fault     <= in_valid && bad;
      byte_en   <= (in_valid && !bad) ? be_nxt : '0;
      if (in_valid && !bad) dst <= nxt;
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst));
  a_r9_bad_field: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vvvv != 4'hF) |=> (fault && byte_en == '0 && $stable(dst)));
  a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_mem) |=> (fault || dst[MAXVL-1:HALF] == '0));
  a_r8_reg_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_mem) |=> byte_en == '0);
  a_r10_short_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy && !len_bit) |=> fault);
endmodule

// File: tb/vec_chunk_extract_test.sv
`timescale 1ns/1ps
module vec_chunk_extract_test;
  typedef struct packed {
    logic [511:0] d;
    logic [63:0]  be;
    logic         f;
  } exp_t;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [511:0] src = '0, old_dst = '0;
  logic [7:0] imm = '0, mask = '0;
  logic src_wide = 0, chunk_wide = 0, elem64 = 0, mask_en = 0, zeroing = 0;
  logic to_mem = 0, legacy = 0, len_bit = 0;
  logic [3:0] vvvv = 4'hF;
  logic out_valid, fault;
  logic [511:0] dst;
  logic [63:0] byte_en;

  int n_tests = 0, n_fail = 0;
  bit done = 0, mon_on = 0;
  exp_t q[$];
  string tq[$];
  logic [511:0] model_dst = '0, last_d = '0;

  always #4 clk = ~clk;

  vec_chunk_extract uut (.clk, .rst_n, .in_valid, .src, .old_dst, .imm, .src_wide,
    .chunk_wide, .elem64, .mask, .mask_en, .zeroing, .to_mem, .legacy, .len_bit,
    .vvvv, .out_valid, .dst, .byte_en, .fault);

  function automatic logic [511:0] pat(input logic [15:0] seed);
    logic [511:0] v;
    for (int l = 0; l < 16; l++)
      v[l*32 +: 32] = {seed[7:0], 8'(l), 8'hA5 ^ 8'(l*3), seed[15:8]};
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [511:0] act, input logic [511:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic drive(input logic sw, cw, e64, me, zr, mem, leg, lb,
                       input logic [3:0] vv, input logic [7:0] im, mk,
                       input logic [511:0] s, od, input string tag);
    exp_t e;
    int base, nl, el;
    bit w, take, flt;
    @(negedge clk);
    src_wide = sw; chunk_wide = cw; elem64 = e64; mask_en = me; zeroing = zr;
    to_mem = mem; legacy = leg; len_bit = lb; vvvv = vv; imm = im; mask = mk;
    src = s; old_dst = od; in_valid = 1;
    flt = (vv != 4'hF) || (leg && !lb) || (!leg && cw && !sw);
    w = cw && !leg;
    if (w) base = im[0] * 256;
    else if (sw && !leg) base = int'(im[1:0]) * 128;
    else base = im[0] * 128;
    nl = w ? 8 : 4;
    e.d = mem ? od : '0;
    e.be = '0;
    e.f = flt;
    for (int l = 0; l < nl; l++) begin
      el = e64 ? l / 2 : l;
      take = leg || !me || mk[el];
      if (take) begin
        e.d[l*32 +: 32] = s[base + l*32 +: 32];
        if (mem) e.be[l*4 +: 4] = 4'hF;
      end else if (!mem && zr) e.d[l*32 +: 32] = '0;
      else e.d[l*32 +: 32] = od[l*32 +: 32];
    end
    if (flt) begin
      e.d = model_dst;
      e.be = '0;
    end else model_dst = e.d;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (out_valid) begin
        if (q.size() == 0) check(0, "R11", "unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = tq.pop_front();
          check(dst === e.d, t, "dst", dst, e.d);
          check(byte_en === e.be, t, "byte_en", 512'(byte_en), 512'(e.be));
          check(fault === e.f, t, "fault", 512'(fault), 512'(e.f));
          last_d = e.d;
        end
      end else
        check(dst === last_d, "R11", "dst hold when idle", dst, last_d);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [511:0] s1, s2, o1, o2;
    s1 = pat(16'h1234); s2 = pat(16'hBEEF);
    o1 = pat(16'h5A5A); o2 = pat(16'h0F0F);
    repeat (3) @(negedge clk);
    check(dst === '0 && byte_en === '0 && !fault && !out_valid, "R11",
          "reset state", dst, '0);
    rst_n = 1;
    mon_on = 1;
    // R1: 256-bit source, 128-bit chunk
    drive(0,0,0,0,0,0,0,0,4'hF,8'h00,8'h00,s1,o1,"R1");
    drive(0,0,0,0,0,0,0,0,4'hF,8'h01,8'h00,s2,o1,"R1");
    // R2: four chunks of a 512-bit source
    for (int k = 0; k < 4; k++)
      drive(1,0,0,0,0,0,0,0,4'hF,8'(k),8'h00,s1,o1,"R2");
    // R3: 256-bit chunks, both element sizes
    drive(1,1,0,0,0,0,0,0,4'hF,8'h00,8'h00,s1,o1,"R3");
    drive(1,1,1,0,0,0,0,0,4'hF,8'h01,8'h00,s2,o1,"R3");
    // R4: high immediate bits ignored
    drive(1,0,0,0,0,0,0,0,4'hF,8'hFE,8'h00,s1,o1,"R4");
    drive(1,1,0,0,0,0,0,0,4'hF,8'hFD,8'h00,s2,o1,"R4");
    drive(0,0,0,0,0,0,0,0,4'hF,8'hAA,8'h00,s1,o1,"R4");
    // R5/R6: masking, merge and zero, 32 and 64-bit elements
    drive(1,0,0,1,0,0,0,0,4'hF,8'h02,8'h05,s1,o1,"R5 merge32");
    drive(1,0,0,1,1,0,0,0,4'hF,8'h03,8'h0A,s1,o1,"R6 zero32");
    drive(1,0,1,1,0,0,0,0,4'hF,8'h01,8'h02,s2,o2,"R5 merge64");
    drive(1,1,1,1,1,0,0,0,4'hF,8'h01,8'h09,s2,o2,"R6 zero64");
    drive(1,1,0,1,0,0,0,0,4'hF,8'h00,8'hA5,s1,o2,"R6 merge256");
    drive(1,1,0,1,1,0,0,0,4'hF,8'h00,8'h00,s1,o2,"R7 all zero");
    // R8: memory destination
    drive(1,0,0,1,0,1,0,0,4'hF,8'h01,8'h06,s1,o1,"R8 mem32");
    drive(1,0,0,1,1,1,0,0,4'hF,8'h01,8'h06,s1,o1,"R8 zeroing ignored");
    drive(1,1,1,1,1,1,0,0,4'hF,8'h01,8'h0C,s2,o2,"R8 mem64");
    drive(0,0,0,0,0,1,0,0,4'hF,8'h01,8'h00,s2,o2,"R8 mem full");
    // R9/R12: faults
    drive(1,0,0,0,0,0,0,0,4'h7,8'h00,8'h00,s2,o2,"R9");
    drive(1,0,0,0,0,1,0,0,4'hE,8'h00,8'h00,s2,o2,"R9 mem");
    drive(0,1,0,0,0,0,0,0,4'hF,8'h00,8'h00,s2,o2,"R12");
    // R10: legacy form
    drive(1,0,0,1,1,0,1,0,4'hF,8'h01,8'h00,s1,o1,"R10 L=0");
    drive(1,0,0,1,1,0,1,1,4'hF,8'h03,8'h00,s1,o1,"R10 full write");
    drive(0,1,0,1,0,1,1,1,4'hF,8'h00,8'h00,s2,o2,"R10 mem");
    // R11: idle hold
    idle(4);
    drive(1,0,0,0,0,0,0,0,4'hF,8'h03,8'h00,s2,o2,"R11");
    idle(4);
    if (q.size() != 0) check(0, "R11", "results missing", 512'(q.size()), 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule